// File: doc/BRIEF.md
# Masked Write Merge for a 32-bit Memory Column

This block sits in the write path of a synchronous memory and works out the word that goes back into a column during a burst write. Each data beat is combined with the word the column holds now, under two masks. A byte-lane mask arrives with every beat. A bit-level mask lives in a register that has its own load strobe.

The bit-level mask is used only in rows that were opened with the masked variant of the activate strobe. That choice is taken once, at activate, and it holds until the row is precharged. Rows opened with the plain activate write through the byte-lane mask alone.

A write strobe starts a burst of `BURST_LEN` beats. The first beat is taken on the same clock edge as the strobe. Each merged word comes out one cycle after its beat, together with a store enable and the beat's index inside the burst. The storage array and the command decoding are outside this block.

Top module: `wmask_merge`

## Requirements
- R1: While reset is held and on the first cycle after it, `st_en_o` is 0, `st_word_o` is 0 and `st_beat_o` is 0. No row is open. The bit mask register holds all ones.
- R2: A `wr_i` pulse seen on a rising edge while a row is open captures that edge's beat. One cycle later `st_en_o` is 1 and `st_beat_o` is 0.
- R3: A burst is `BURST_LEN` (default 4) beats on consecutive edges, and `st_beat_o` counts 0 to `BURST_LEN`-1. Beats that arrive after the last one are discarded, so `st_en_o` stays 0 for them.
- R4: Bit 8k+j of the merged word keeps `old_i` when `dqm_i[k]` was 1 at that beat. Here k is 0 to 3, j is 0 to 7, and byte 0 is bits 7:0.
- R5: In a row opened with `act_i`=1 and `act_wpb_i`=1, a bit whose byte lane is enabled is taken from `data_i` where the bit mask register is 1. Where the register is 0, the bit keeps `old_i`.
- R6: In a row opened with `act_i`=1 and `act_wpb_i`=0, the bit mask register has no effect. Every bit of an enabled byte lane comes from `data_i`.
- R7: The row mode is latched at activate and cleared by `pre_i`. `pre_i` wins over `act_i` and `wr_i` on the same edge. An edge with `pre_i` or `act_i` ends any burst and discards its beat. `wr_i` with no row open is ignored.
- R8: `mask_ld_i` loads `mask_val_i` into the bit mask register. The new value applies to beats from the next edge onward. A beat on the loading edge still uses the previous value.
- R9: A `wr_i` during a burst starts a new burst at beat 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Row activate strobe |
| act_wpb_i | input | 1 | With `act_i`: 1 opens the row in bit-masked mode |
| pre_i | input | 1 | Precharge strobe that closes the row |
| mask_ld_i | input | 1 | Load strobe for the bit mask register |
| mask_val_i | input | 32 | Value for the bit mask register |
| wr_i | input | 1 | Write command; the beat on this edge is the first |
| data_i | input | 32 | Write data beat |
| dqm_i | input | 4 | Byte-lane masks, 1 keeps the stored byte |
| old_i | input | 32 | Word the column holds now, for this beat |
| st_word_o | output | 32 | Merged word to store |
| st_en_o | output | 1 | Store enable for `st_word_o` |
| st_beat_o | output | 2 | Beat index of the stored word inside its burst |

## Verification
Every result is due exactly one clock after the edge that captures its inputs. This covers the store enable, the merged word and the beat index. A mask load, a row-mode change or a burst count change only affects beats from the following edge on.

The bench drives inputs on the falling edge. From those inputs and its own model of row, mode, mask and burst count, it computes the expected outputs before the rising edge. It compares them at the next falling edge, which is one register stage later.

// File: rtl/wmask_merge.sv
module wmask_merge #(
  parameter int WORD_W    = 32,
  parameter int BURST_LEN = 4,
  localparam int NBYTE  = WORD_W / 8,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              act_wpb_i,
  input  logic              pre_i,
  input  logic              mask_ld_i,
  input  logic [WORD_W-1:0] mask_val_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [NBYTE-1:0]  dqm_i,
  input  logic [WORD_W-1:0] old_i,
  output logic [WORD_W-1:0] st_word_o,
  output logic              st_en_o,
  output logic [BEAT_W-1:0] st_beat_o
);

  logic              row_q, wpb_q;
  logic [WORD_W-1:0] mask_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              burst_q;

  logic [WORD_W-1:0] lane_keep;
  logic [WORD_W-1:0] wr_bits;
  logic              cap;
  logic [BEAT_W-1:0] idx;
  logic              last;

  for (genvar k = 0; k < NBYTE; k++) begin : g_lane
    assign lane_keep[k*8 +: 8] = {8{dqm_i[k]}};
  end

  assign wr_bits = ~lane_keep & (wpb_q ? mask_q : '1);
  assign cap     = row_q && !pre_i && !act_i && (wr_i || burst_q);
  assign idx     = wr_i ? '0 : cnt_q;
  assign last    = (idx == BEAT_W'(BURST_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= 1'b0;
      wpb_q <= 1'b0;
    end else if (pre_i) begin
      row_q <= 1'b0;
      wpb_q <= 1'b0;
    end else if (act_i) begin
      row_q <= 1'b1;
      wpb_q <= act_wpb_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (mask_ld_i) mask_q <= mask_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (cap && !last) begin
      cnt_q   <= idx + 1'b1;
      burst_q <= 1'b1;
    end else begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_en_o   <= 1'b0;
      st_word_o <= '0;
      st_beat_o <= '0;
    end else begin
      st_en_o <= cap;
      if (cap) begin
        st_word_o <= (data_i & wr_bits) | (old_i & ~wr_bits);
        st_beat_o <= idx;
      end
    end
  end

endmodule

// File: rtl/wmask_merge_chk.sv
module wmask_merge_chk #(
  parameter int WORD_W = 32,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_q,
  input logic              wpb_q,
  input logic [WORD_W-1:0] mask_q,
  input logic              pre_i,
  input logic              act_i,
  input logic              wr_i,
  input logic [WORD_W-1:0] data_i,
  input logic [WORD_W/8-1:0] dqm_i,
  input logic [WORD_W-1:0] old_i,
  input logic [WORD_W-1:0] st_word_o,
  input logic              st_en_o,
  input logic [BEAT_W-1:0] st_beat_o
);

  logic [WORD_W-1:0] keep_x;
  always_comb
    for (int k = 0; k < WORD_W / 8; k++) keep_x[k*8 +: 8] = {8{dqm_i[k]}};

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && row_q && !pre_i && !act_i) |=> (st_en_o && st_beat_o == '0));

  a_r4_dqm_keep: assert property (@(posedge clk) disable iff (!rst_n)
    st_en_o |-> (((st_word_o ^ $past(old_i)) & $past(keep_x)) == '0));

  a_r5_bitmask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en_o && $past(wpb_q)) |-> (((st_word_o ^ $past(old_i)) & ~$past(mask_q)) == '0));

  a_r6_plain_row: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en_o && !$past(wpb_q)) |-> (((st_word_o ^ $past(data_i)) & ~$past(keep_x)) == '0));

  a_r7_pre_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i || act_i) |=> !st_en_o);

  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en_o && st_beat_o != '0) |-> ($past(st_en_o) && st_beat_o == $past(st_beat_o) + 1'b1));

endmodule

bind wmask_merge wmask_merge_chk #(.WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_q(row_q), .wpb_q(wpb_q), .mask_q(mask_q),
  .pre_i(pre_i), .act_i(act_i), .wr_i(wr_i), .data_i(data_i), .dqm_i(dqm_i),
  .old_i(old_i), .st_word_o(st_word_o), .st_en_o(st_en_o), .st_beat_o(st_beat_o)
);

// File: tb/sim_wmask_merge.sv
module sim_wmask_merge;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic act, act_wpb, pre, mld, wr;
  logic [31:0] mval, data, old;
  logic [3:0] dqm;
  logic [31:0] st_word;
  logic st_en;
  logic [1:0] st_beat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit m_row = 0, m_wpb = 0, m_burst = 0;
  logic [31:0] m_mask = '1;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wmask_merge u0 (
    .clk(clk), .rst_n(rst_n), .act_i(act), .act_wpb_i(act_wpb), .pre_i(pre),
    .mask_ld_i(mld), .mask_val_i(mval), .wr_i(wr), .data_i(data), .dqm_i(dqm),
    .old_i(old), .st_word_o(st_word), .st_en_o(st_en), .st_beat_o(st_beat)
  );

  function automatic logic [31:0] exp_merge(logic [31:0] d, logic [31:0] o,
                                            logic [3:0] q, logic [31:0] m, bit wpb);
    logic [31:0] en;
    for (int k = 0; k < 4; k++) en[k*8 +: 8] = q[k] ? 8'h00 : 8'hFF;
    if (wpb) en = en & m;
    return (d & en) | (o & ~en);
  endfunction

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic idle();
    act = 0; act_wpb = 0; pre = 0; mld = 0; mval = '0; wr = 0;
    data = $urandom; old = $urandom; dqm = 4'h0;
  endtask

  // one clock: model computes expectation, then outputs compared one register later
  task automatic tick(string tag);
    bit cap, e_en;
    int idx;
    logic [31:0] e_word;
    cap = m_row && !pre && !act && (wr || m_burst);
    idx = wr ? 0 : m_cnt;
    e_en = cap;
    e_word = exp_merge(data, old, dqm, m_mask, m_wpb);
    if (pre) begin m_row = 0; m_wpb = 0; end
    else if (act) begin m_row = 1; m_wpb = act_wpb; end
    if (mld) m_mask = mval;
    if (cap && idx != BL-1) begin m_cnt = idx + 1; m_burst = 1; end
    else begin m_cnt = 0; m_burst = 0; end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " en"}, 32'(st_en), 32'(e_en));
    if (e_en && st_en) begin
      chk({tag, " word"}, st_word, e_word);
      chk({tag, " beat"}, 32'(st_beat), 32'(idx));
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 en", 32'(st_en), 0);
    chk("R1 word", st_word, 0);
    chk("R1 beat", 32'(st_beat), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en after release", 32'(st_en), 0);

    // R7: write with no row open is ignored
    wr = 1; tick("R7 no row");
    // R1 mask of all ones reaches the output: masked row, full write
    act = 1; act_wpb = 1; tick("R7 act");
    wr = 1; data = 32'hA5A5_5A5A; tick("R1 mask ones");
    repeat (BL-1) tick("R3 beats");
    pre = 1; tick("R7 pre");

    // R6: plain row ignores a zero bit mask
    mld = 1; mval = 32'h0; act = 1; act_wpb = 0; tick("R8 load");
    wr = 1; dqm = 4'b0101; tick("R6 plain row");
    dqm = 4'b1111; tick("R4 all lanes kept");
    tick("R6 beat2");
    dqm = 4'b1000; tick("R4 top lane");
    // R3: extra data after burst is discarded
    tick("R3 extra1");
    tick("R3 extra2");
    pre = 1; tick("R7 pre");

    // R5: masked row with zero mask keeps everything
    act = 1; act_wpb = 1; tick("R7 act wpb");
    wr = 1; tick("R5 zero mask");
    // R8: load on the same edge as a beat, effect next beat
    mld = 1; mval = 32'hF0F0_0FF0; tick("R8 same edge");
    tick("R8 next edge");
    // R9: restart mid-burst
    wr = 1; tick("R9 restart");
    tick("R9 beat1");
    // R7: precharge mid-burst discards beat and ends burst
    pre = 1; wr = 1; tick("R7 pre mid");
    tick("R7 after pre");
    act = 1; act_wpb = 0; tick("R7 reopen plain");
    wr = 1; tick("R7 plain after masked");
    act = 1; act_wpb = 1; tick("R7 act mid burst");
    tick("R7 after act");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      pre = (r < 4);
      act = (r >= 4 && r < 9);
      act_wpb = $urandom_range(0, 1);
      wr = ($urandom_range(0, 99) < 15);
      mld = ($urandom_range(0, 99) < 8);
      mval = $urandom;
      dqm = 4'($urandom);
      tick("R4/R5/R6 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule